// File: doc/BRIEF.md
# GPIO Port Bank with Change Interrupt

This block is the register side of a small serial-controlled port expander. It holds the direction, output-data and read-polarity state for four general-purpose pins. It also drives the per-pin output enable and output data toward the pads. A bus interface elsewhere on the chip decodes the serial protocol. It hands the bank a two-bit register select, a write strobe with a data byte and a read strobe, and takes a byte of read data back. Pin levels arrive asynchronously and pass through a two-flop synchronizer before anything uses them.

The bank keeps a snapshot of the pin levels, taken each time the input register is read. An active-low, open-drain interrupt is pulled low while any pin set as an input disagrees with that snapshot. It lets go when the pin returns to its snapshot level, or when software reads the input register, which takes a new snapshot. The polarity setting changes only the read data, never the snapshot comparison. Read data is combinational on the current select. A read strobe acts at the next clock edge.

Top module: `gpx_port_bank`

## Requirements
- R1: After reset the output enable `pin_oe` is 0 for every pin and `irq_low_en` is 0. Register reads then return output 0xFF, polarity 0x00 and configuration 0xFF. The snapshot resets to all ones.
- R2: Select 3 is the configuration register. A 1 in bit n makes pin n an input with `pin_oe[n]`=0, and a 0 makes it an output with `pin_oe[n]`=1. The new value takes effect on the edge that takes the write, and `pin_out` carries the output register.
- R3: A read of select 0 returns the synchronized level of every pin in bits 3..0, whatever direction the pin has. A pin change shows up two clock edges after it is applied. A write to select 0 changes no state.
- R4: Select 1 is the output register. A read of it returns the stored value, not the pin level.
- R5: Select 2 is the polarity register. A 1 in bit n inverts bit n of the select-0 read data. It has no effect on `pin_out` or on the interrupt.
- R6: Read bits 7..4 are 1 for selects 0, 1 and 3, and 0 for select 2. The upper bits of write data are discarded.
- R7: `irq_low_en` becomes 1 on the second edge after an input-configured pin moves away from its snapshot level. Pins configured as outputs never raise it.
- R8: `irq_low_en` returns to 0 once every input-configured pin is back at its snapshot level.
- R9: A read strobe on select 0 stores the value being read, before polarity, as the new snapshot. Unless a pin changes at the same time, `irq_low_en` is 0 after that edge.
- R10: Turning an output into an input whose level differs from the snapshot raises `irq_low_en` on the edge of the configuration write.
- R11: While `rst_n` is low, all registers keep their reset values and writes are ignored. `pin_oe` stays 0 and `irq_low_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acts on the snapshot at select 0) |
| reg_sel | input | 2 | Register select: 0 input, 1 output, 2 polarity, 3 configuration |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current select |
| pin_in | input | 4 | Asynchronous pin levels |
| pin_oe | output | 4 | Per-pin output driver enable |
| pin_out | output | 4 | Per-pin output data |
| irq_low_en | output | 1 | When 1, the open-drain interrupt line is pulled low |

## Verification
The change detector gets a pin that moves and comes back, a pin that moves and is then read, and output pins that move. These show apart the release-on-return path, the release-on-read path and the direction mask. An output-to-input switch against a stale snapshot checks that the false interrupt is raised, not masked. Polarity is set while an interrupt is possible, to show that it touches only the read data. Reads of the output register while the pin levels disagree with it show the stored value apart from the pin. A sample one edge after a pin change confirms the two-edge synchronizer latency.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_CFG = 2'd3
    } gpx_sel_e;

endpackage

// File: rtl/gpx_sync2.sv
module gpx_sync2 #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] stage1,
    output logic [W-1:0] stage2
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_in;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign stage1 = s1_q;
    assign stage2 = s2_q;
endmodule

// File: rtl/gpx_change_det.sv
module gpx_change_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_mask_d,
    input  logic [W-1:0] level_d,
    input  logic [W-1:0] snap_d,
    output logic         irq_q
);
    logic         irq_d;
    logic [W-1:0] diff;

    always_comb begin
        diff  = in_mask_d & (level_d ^ snap_d);
        irq_d = |diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end
endmodule

// File: rtl/gpx_rdmux.sv
module gpx_rdmux
    import gpx_pkg::*;
#(
    parameter int W     = 4,
    parameter int REG_W = 8
) (
    input  gpx_sel_e         sel,
    input  logic [W-1:0]     level,
    input  logic [W-1:0]     pol,
    input  logic [W-1:0]     outr,
    input  logic [W-1:0]     cfg,
    output logic [REG_W-1:0] data
);
    localparam int PAD_W = REG_W - W;

    always_comb begin
        unique case (sel)
            SEL_IN:  data = {{PAD_W{1'b1}}, level ^ pol};
            SEL_OUT: data = {{PAD_W{1'b1}}, outr};
            SEL_POL: data = {{PAD_W{1'b0}}, pol};
            default: data = {{PAD_W{1'b1}}, cfg};
        endcase
    end
endmodule

// File: rtl/gpx_port_bank.sv
module gpx_port_bank
    import gpx_pkg::*;
#(
    parameter int PINS  = 4,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [PINS-1:0]  pin_in,
    output logic [PINS-1:0]  pin_oe,
    output logic [PINS-1:0]  pin_out,
    output logic             irq_low_en
);
    localparam logic [PINS-1:0] ONES = '1;
    localparam logic [PINS-1:0] ZERO = '0;

    typedef struct packed {
        logic [PINS-1:0] outr;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] cfg;
        logic [PINS-1:0] snap;
    } bank_t;

    localparam bank_t BANK_RST = '{outr: ONES, pol: ZERO, cfg: ONES, snap: ONES};

    bank_t           st_d, st_q;
    gpx_sel_e        sel;
    logic [PINS-1:0] smp_nx;
    logic [PINS-1:0] smp_q;

    assign sel = gpx_sel_e'(reg_sel);

    gpx_sync2 #(.W(PINS), .RST_VAL(ONES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .stage1   (smp_nx),
        .stage2   (smp_q)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (sel)
                SEL_OUT: st_d.outr = wr_data[PINS-1:0];
                SEL_POL: st_d.pol  = wr_data[PINS-1:0];
                SEL_CFG: st_d.cfg  = wr_data[PINS-1:0];
                default: ;
            endcase
        end
        if (rd_en && sel == SEL_IN) begin
            st_d.snap = smp_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BANK_RST;
        else        st_q <= st_d;
    end

    gpx_change_det #(.W(PINS)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_mask_d (st_d.cfg),
        .level_d   (smp_nx),
        .snap_d    (st_d.snap),
        .irq_q     (irq_low_en)
    );

    gpx_rdmux #(.W(PINS), .REG_W(REG_W)) u_rd (
        .sel   (sel),
        .level (smp_q),
        .pol   (st_q.pol),
        .outr  (st_q.outr),
        .cfg   (st_q.cfg),
        .data  (rd_data)
    );

    assign pin_oe  = ~st_q.cfg;
    assign pin_out = st_q.outr;
endmodule

// File: rtl/gpx_port_bank_chk.sv
module gpx_port_bank_chk #(
    parameter int PINS  = 4,
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [1:0]       reg_sel,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic [PINS-1:0]  pin_oe,
    input logic [PINS-1:0]  pin_out,
    input logic             irq_low_en,
    input logic [PINS-1:0]  smp_q,
    input logic [PINS-1:0]  smp_nx
);
    localparam int PAD_W = REG_W - PINS;

    assert_reset_dflt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && !irq_low_en));

    assert_out_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd1) |=> (pin_out == $past(wr_data[PINS-1:0])));

    assert_in_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && reg_sel == 2'd0) |=> ($stable(pin_oe) && $stable(pin_out)));

    assert_upper_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd2) ? (rd_data[REG_W-1:PINS] == {PAD_W{1'b0}})
                          : (rd_data[REG_W-1:PINS] == {PAD_W{1'b1}}));

    assert_irq_needs_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_low_en) |-> (pin_oe != '1));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == 2'd0 && smp_nx == smp_q) |=> !irq_low_en);

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_held_reset_R11: assert (pin_oe == '0 && !irq_low_en);
        end
    end
endmodule

bind gpx_port_bank gpx_port_bank_chk #(.PINS(PINS), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .reg_sel    (reg_sel),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .irq_low_en (irq_low_en),
    .smp_q      (smp_q),
    .smp_nx     (smp_nx)
);

// File: tb/gpx_port_bank_test.sv
`timescale 1ns/1ps
module gpx_port_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] pin_in = 4'hF;
    logic [3:0] pin_oe;
    logic [3:0] pin_out;
    logic       irq_low_en;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int W_RD = 0, W_OE = 1, W_OUT = 2, W_IRQ = 3;

    typedef struct {
        int       cyc;
        int       what;
        logic [7:0] exp;
        string    tag;
    } sb_item_t;

    sb_item_t sbq[$];

    gpx_port_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .irq_low_en(irq_low_en)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares due expectations half a cycle after the edge
    always @(negedge clk) begin : mon
        sb_item_t   it;
        logic [7:0] obs;
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            it = sbq.pop_front();
            case (it.what)
                W_RD:    obs = rd_data;
                W_OE:    obs = {4'h0, pin_oe};
                W_OUT:   obs = {4'h0, pin_out};
                default: obs = {7'h0, irq_low_en};
            endcase
            checks++;
            if (obs !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_now(int what, logic [7:0] exp, string tag);
        sbq.push_back('{cyc: cyc, what: what, exp: exp, tag: tag});
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, logic strobe, logic [7:0] exp, string tag);
        reg_sel = sel; rd_en = strobe;
        expect_now(W_RD, exp, tag);
        step(1);
        rd_en = 1'b0;
    endtask

    initial begin
        // R11: writes during reset are ignored, outputs held at defaults
        step(1);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h00);
        expect_now(W_OE, 8'h00, "R11 oe held in reset");
        expect_now(W_IRQ, 8'h00, "R11 irq held in reset");
        step(1);
        rst_n = 1'b1;
        step(1);

        // R1 defaults
        expect_now(W_OE, 8'h00, "R1 all pins inputs");
        expect_now(W_IRQ, 8'h00, "R1 irq released");
        expect_now(W_OUT, 8'h0F, "R1 pin_out default");
        rd(2'd1, 1'b0, 8'hFF, "R1 output reg default");
        rd(2'd2, 1'b0, 8'h00, "R1 polarity default");
        rd(2'd3, 1'b0, 8'hFF, "R1 config default");

        // R7 latency and R3 input read
        pin_in = 4'b1010;
        step(1);
        expect_now(W_IRQ, 8'h00, "R7 not yet after one edge");
        step(1);
        expect_now(W_IRQ, 8'h01, "R7 raised on second edge");
        rd(2'd0, 1'b1, 8'hFA, "R3 input read");
        expect_now(W_IRQ, 8'h00, "R9 cleared by read");
        step(1);

        // R8 release on return
        pin_in = 4'b1000;
        step(2);
        expect_now(W_IRQ, 8'h01, "R8 raised by change");
        pin_in = 4'b1010;
        step(2);
        expect_now(W_IRQ, 8'h00, "R8 released on return");

        // R3 write to input register ignored
        wr(2'd0, 8'h00);
        expect_now(W_OE, 8'h00, "R3 input write no oe change");
        expect_now(W_OUT, 8'h0F, "R3 input write no out change");
        rd(2'd0, 1'b0, 8'hFA, "R3 input read after ignored write");

        // R5 polarity on read data only
        wr(2'd2, 8'hF3);
        rd(2'd2, 1'b0, 8'h03, "R6 polarity upper bits zero");
        rd(2'd0, 1'b0, 8'hF9, "R5 inverted input read");
        expect_now(W_IRQ, 8'h00, "R5 polarity no irq");
        expect_now(W_OUT, 8'h0F, "R5 polarity no pin_out change");
        step(1);

        // R2 / R4 / R6 output and configuration
        wr(2'd1, 8'h05);
        rd(2'd1, 1'b0, 8'hF5, "R4 output read upper ones");
        wr(2'd3, 8'hFC);
        expect_now(W_OE, 8'h03, "R2 low pins driven");
        expect_now(W_OUT, 8'h05, "R2 pin_out carries output reg");
        rd(2'd3, 1'b0, 8'hFC, "R2 config read");
        pin_in = 4'b1001;  // pins 1:0 now disagree with output reg
        step(2);
        rd(2'd1, 1'b0, 8'hF5, "R4 stored value not pin");
        rd(2'd0, 1'b0, 8'hFA, "R3 output pins visible in input read");
        expect_now(W_IRQ, 8'h00, "R7 output pins ignored");
        wr(2'd1, 8'h0A);
        rd(2'd1, 1'b0, 8'hFA, "R6 upper write bits discarded");

        // R10 output to input switch against stale snapshot
        wr(2'd3, 8'hFF);
        expect_now(W_IRQ, 8'h01, "R10 false interrupt on direction change");
        expect_now(W_OE, 8'h00, "R10 all inputs");
        rd(2'd0, 1'b1, 8'hFA, "R9 strobe read");
        expect_now(W_IRQ, 8'h00, "R9 released after read");
        step(1);

        // R11 reset mid-operation
        wr(2'd3, 8'hF0);
        rst_n = 1'b0;
        step(1);
        expect_now(W_OE, 8'h00, "R11 reset forces inputs");
        rd(2'd1, 1'b0, 8'hFF, "R11 output reg in reset");
        rst_n = 1'b1;
        step(1);
        rd(2'd2, 1'b0, 8'h00, "R1 polarity after reset");
        step(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule